// File: doc/BRIEF.md
# UART Interrupt Flag Aggregator

This block gathers the event and error indications of a UART into five latched flags and merges them into one level-sensitive interrupt request. Three causes reach the request line: transmit holding buffer emptied, receive buffer holding data, and receive error. The receive error cause is the OR of three separate error flags: overrun, framing and parity. Each cause is gated by its own enable bit. A flag latches whether or not its cause is enabled, so a handler can poll a masked cause. When the request is raised, the handler reads the flag word to find out which cause is active.

The transmit-empty flag is set by a one-cycle pulse. The transmit datapath sends that pulse when it moves a byte from its holding buffer into its shift register, not when the frame has gone out on the line. Each flag bit is a small two-state machine. FLG_IDLE moves to FLG_PEND on a set pulse. FLG_PEND returns to FLG_IDLE on a clear with no set in the same cycle. Otherwise a cell stays in its state. Four of the cells clear when a 1 is written to their bit. The receive-full cell clears only on a pulse that says the buffer has been read empty, so it follows buffer occupancy.

Top module: `uart_irq_agg`

## Requirements
- R1: After reset the flag word, the enable word and `irq_o` are all 0.
- R2: A `tx_load_i` pulse sets flag bit 0 (transmit empty), and the new value is seen from the cycle after the sampling edge.
- R3: A `rx_push_i` pulse sets flag bit 1 (receive full) and a `rx_drained_i` pulse clears it. Writing 1 to bit 1 of the flag word has no effect.
- R4: Pulses on `err_overrun_i`, `err_framing_i` and `err_parity_i` set flag bits 2, 3 and 4 respectively, each on its own. The receive error cause is the OR of these three bits.
- R5: A write to address 0 clears every flag among bits 0, 2, 3 and 4 whose data bit is 1. Flags whose data bit is 0 stay as they are.
- R6: When a set pulse and a clear for the same flag come in the same cycle, the flag ends up set.
- R7: While a cause's enable bit is 0, that cause never drives `irq_o`, but its flags still latch and can be read back.
- R8: `irq_o` equals (bit0 AND en0) OR (bit1 AND en1) OR ((bit2 OR bit3 OR bit4) AND en2). It is driven from the registered state with no added delay, so it rises in the same cycle as the flag that causes it.
- R9: A write to address 1 loads the enable word from data bits 2..0 (bit 0 transmit empty, bit 1 receive full, bit 2 receive error), and a read of address 1 returns that word. Writes to addresses 2 and 3 change nothing, and reads of addresses 2 and 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_load_i | input | 1 | Pulse: holding buffer moved into the transmit shift register |
| rx_push_i | input | 1 | Pulse: received byte placed in the receive buffer |
| rx_drained_i | input | 1 | Pulse: receive buffer read down to empty |
| err_overrun_i | input | 1 | Pulse: overrun detected |
| err_framing_i | input | 1 | Pulse: bad stop bit detected |
| err_parity_i | input | 1 | Pulse: parity mismatch detected |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | ADDR_W | Host write address (0 flags, 1 enables) |
| wr_data_i | input | DATA_W | Host write data |
| rd_addr_i | input | ADDR_W | Host read address |
| rd_data_o | output | DATA_W | Read data for `rd_addr_i`, combinational |
| irq_o | output | 1 | Shared interrupt request, level |

## Verification
Every pulse and host write is sampled at one rising edge. The flag word, the enable word and `irq_o` show the result from just after that same edge, with no extra cycle of delay. The bench drives its inputs between edges and moves its reference model forward one step per edge. It then compares `rd_data_o` and `irq_o` 1 ns after the edge, once the registers have settled and before the next inputs are applied. Random traffic runs alongside directed cases: a set and a clear in the same cycle, masked causes, a write-1 to the occupancy flag, and the unmapped addresses.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    typedef enum logic {
        FLG_IDLE = 1'b0,
        FLG_PEND = 1'b1
    } flag_state_e;

    localparam int NUM_FLAGS  = 5;
    localparam int NUM_CAUSES = 3;

    localparam int BIT_TXE = 0;
    localparam int BIT_RXF = 1;
    localparam int BIT_OVR = 2;
    localparam int BIT_FRM = 3;
    localparam int BIT_PAR = 4;

    localparam int EN_TXE = 0;
    localparam int EN_RXF = 1;
    localparam int EN_ERR = 2;
endpackage

// File: rtl/uart_irq_flag_cell.sv
module uart_irq_flag_cell
    import uart_irq_pkg::*;
#(
    parameter bit CLR_BY_W1C = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic w1c_i,
    input  logic clr_evt_i,
    output logic flag_o
);
    flag_state_e state_q, state_d;
    logic        clr;

    assign clr = CLR_BY_W1C ? w1c_i : clr_evt_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: if (set_i)         state_d = FLG_PEND;
            FLG_PEND: if (clr && !set_i) state_d = FLG_IDLE;
            default:                     state_d = FLG_IDLE;
        endcase
    end

    always_comb begin
        flag_o = (state_q == FLG_PEND);
    end

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && clr && !set_i) |=> !flag_o);
endmodule

// File: rtl/uart_irq_enable_reg.sv
module uart_irq_enable_reg
    import uart_irq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_i,
    input  logic [NUM_CAUSES-1:0] data_i,
    output logic [NUM_CAUSES-1:0] en_o
);
    logic [NUM_CAUSES-1:0] en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      en_q <= '0;
        else if (load_i) en_q <= data_i;
    end

    assign en_o = en_q;

    assert_en_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(en_q));
endmodule

// File: rtl/uart_irq_combine.sv
module uart_irq_combine
    import uart_irq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_FLAGS-1:0]  flags_i,
    input  logic [NUM_CAUSES-1:0] en_i,
    output logic                  irq_o
);
    logic [NUM_CAUSES-1:0] cause;

    always_comb begin
        cause         = '0;
        cause[EN_TXE] = flags_i[BIT_TXE];
        cause[EN_RXF] = flags_i[BIT_RXF];
        cause[EN_ERR] = flags_i[BIT_OVR] | flags_i[BIT_FRM] | flags_i[BIT_PAR];
    end

    assign irq_o = |(cause & en_i);

    assert_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i == '0) |-> !irq_o);

    assert_err_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i[EN_ERR] && (flags_i[BIT_FRM] || flags_i[BIT_PAR])) |-> irq_o);
endmodule

// File: rtl/uart_irq_agg.sv
module uart_irq_agg
    import uart_irq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_load_i,
    input  logic              rx_push_i,
    input  logic              rx_drained_i,
    input  logic              err_overrun_i,
    input  logic              err_framing_i,
    input  logic              err_parity_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] ADDR_FLAGS = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_EN    = ADDR_W'(1);

    logic [NUM_FLAGS-1:0]  set_v;
    logic [NUM_FLAGS-1:0]  w1c_v;
    logic [NUM_FLAGS-1:0]  flags;
    logic [NUM_CAUSES-1:0] en_q;
    logic                  wr_flags;
    logic                  wr_en_reg;

    assign wr_flags  = wr_en_i && (wr_addr_i == ADDR_FLAGS);
    assign wr_en_reg = wr_en_i && (wr_addr_i == ADDR_EN);

    always_comb begin
        set_v          = '0;
        set_v[BIT_TXE] = tx_load_i;
        set_v[BIT_RXF] = rx_push_i;
        set_v[BIT_OVR] = err_overrun_i;
        set_v[BIT_FRM] = err_framing_i;
        set_v[BIT_PAR] = err_parity_i;
        w1c_v          = wr_flags ? wr_data_i[NUM_FLAGS-1:0] : '0;
    end

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        uart_irq_flag_cell #(
            .CLR_BY_W1C(i != BIT_RXF)
        ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (set_v[i]),
            .w1c_i    (w1c_v[i]),
            .clr_evt_i(rx_drained_i),
            .flag_o   (flags[i])
        );
    end

    uart_irq_enable_reg u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(wr_en_reg),
        .data_i(wr_data_i[NUM_CAUSES-1:0]),
        .en_o  (en_q)
    );

    uart_irq_combine u_comb (
        .clk    (clk),
        .rst_n  (rst_n),
        .flags_i(flags),
        .en_i   (en_q),
        .irq_o  (irq_o)
    );

    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == ADDR_FLAGS)   rd_data_o = DATA_W'(flags);
        else if (rd_addr_i == ADDR_EN) rd_data_o = DATA_W'(en_q);
    end

    assert_tx_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_load_i && en_q[EN_TXE] && !wr_en_reg) |=> irq_o);

    assert_rx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[BIT_RXF] && !rx_drained_i) |=> flags[BIT_RXF]);
endmodule

// File: tb/uart_irq_agg_tb.sv
module uart_irq_agg_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_load_i = 0, rx_push_i = 0, rx_drained_i = 0;
    logic       err_overrun_i = 0, err_framing_i = 0, err_parity_i = 0;
    logic       wr_en_i = 0;
    logic [1:0] wr_addr_i = 0;
    logic [7:0] wr_data_i = 0;
    logic [1:0] rd_addr_i = 0;
    logic [7:0] rd_data_o;
    logic       irq_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [4:0] m_f = '0;
    logic [2:0] m_e = '0;

    always #2 clk = ~clk;

    uart_irq_agg u_dut (
        .clk(clk), .rst_n(rst_n),
        .tx_load_i(tx_load_i), .rx_push_i(rx_push_i), .rx_drained_i(rx_drained_i),
        .err_overrun_i(err_overrun_i), .err_framing_i(err_framing_i),
        .err_parity_i(err_parity_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
    );

    function automatic logic exp_irq(logic [4:0] f, logic [2:0] e);
        return (f[0] & e[0]) | (f[1] & e[1]) | ((|f[4:2]) & e[2]);
    endfunction

    function automatic logic [7:0] exp_read(logic [1:0] a, logic [4:0] f, logic [2:0] e);
        if (a == 2'd0) return {3'b0, f};
        if (a == 2'd1) return {5'b0, e};
        return 8'h00;
    endfunction

    function automatic logic [4:0] next_flags(logic [4:0] f, logic [4:0] set,
                                              logic drain, logic [4:0] w1c);
        logic [4:0] n;
        logic [4:0] clr;
        clr    = w1c & 5'b11101;
        clr[1] = drain;
        for (int i = 0; i < 5; i++)
            n[i] = set[i] ? 1'b1 : (clr[i] ? 1'b0 : f[i]);
        return n;
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic clear_inputs();
        tx_load_i = 0; rx_push_i = 0; rx_drained_i = 0;
        err_overrun_i = 0; err_framing_i = 0; err_parity_i = 0;
        wr_en_i = 0; wr_addr_i = 0; wr_data_i = 0;
    endtask

    // one edge: update model from driven inputs, compare after the edge
    task automatic tick(string tag);
        logic [4:0] set;
        logic [4:0] w1c;
        @(posedge clk);
        #1;
        set = {err_parity_i, err_framing_i, err_overrun_i, rx_push_i, tx_load_i};
        w1c = (wr_en_i && wr_addr_i == 2'd0) ? wr_data_i[4:0] : 5'b0;
        m_f = next_flags(m_f, set, rx_drained_i, w1c);
        if (wr_en_i && wr_addr_i == 2'd1) m_e = wr_data_i[2:0];
        clear_inputs();
        check({tag, " read"}, rd_data_o, exp_read(rd_addr_i, m_f, m_e));
        check({tag, " irq R8"}, {7'b0, irq_o}, {7'b0, exp_irq(m_f, m_e)});
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
    endtask

    initial begin
        #400000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1;
        rd_addr_i = 0;
        check("R1 flags after reset", rd_data_o, 8'h00);
        check("R1 irq after reset", {7'b0, irq_o}, 8'h00);
        rst_n = 1;
        rd_addr_i = 1;
        tick("R1 enables after reset");

        // R7: masked cause still latches
        rd_addr_i = 0;
        tx_load_i = 1;
        tick("R2 tx flag set");
        check("R7 masked irq", {7'b0, irq_o}, 8'h00);
        check("R7 flag polled", rd_data_o, 8'h01);
        wr(2'd1, 8'h01); rd_addr_i = 1;
        tick("R9 enable write");
        check("R8 irq after enable", {7'b0, irq_o}, 8'h01);
        rd_addr_i = 0;
        wr(2'd0, 8'h00);
        tick("R5 write zero keeps");
        check("R5 flag kept", rd_data_o, 8'h01);
        wr(2'd0, 8'h01);
        tick("R5 w1c tx");
        check("R5 tx cleared", rd_data_o, 8'h00);

        // R6: set and clear same cycle
        tx_load_i = 1; tick("R6 prep");
        tx_load_i = 1; wr(2'd0, 8'h01);
        tick("R6 set wins");
        check("R6 flag", rd_data_o, 8'h01);
        wr(2'd0, 8'h1F); tick("R5 clear all");

        // R3: receive full occupancy
        wr(2'd1, 8'h02); tick("R9 enable rx");
        rx_push_i = 1; tick("R3 push");
        check("R3 irq rx", {7'b0, irq_o}, 8'h01);
        wr(2'd0, 8'h02); tick("R3 w1c ignored");
        check("R3 still full", rd_data_o, 8'h02);
        rx_push_i = 1; rx_drained_i = 1; tick("R6 push+drain");
        check("R6 rx stays", rd_data_o, 8'h02);
        rx_drained_i = 1; tick("R3 drain");
        check("R3 empty", rd_data_o, 8'h00);

        // R4: each error alone, OR into the error cause
        wr(2'd1, 8'h04); tick("R9 enable err");
        err_overrun_i = 1; tick("R4 overrun");
        check("R4 ovr bit", rd_data_o, 8'h04);
        wr(2'd0, 8'h04); err_framing_i = 1; tick("R4 framing");
        check("R4 frm bit", rd_data_o, 8'h08);
        check("R4 irq frm", {7'b0, irq_o}, 8'h01);
        wr(2'd0, 8'h08); err_parity_i = 1; tick("R4 parity");
        check("R4 par bit", rd_data_o, 8'h10);
        wr(2'd0, 8'h10); tick("R5 err cleared");
        check("R4 irq drop", {7'b0, irq_o}, 8'h00);

        // R9: unmapped addresses
        wr(2'd2, 8'hFF); rd_addr_i = 2; tick("R9 addr2");
        check("R9 addr2 zero", rd_data_o, 8'h00);
        wr(2'd3, 8'hFF); rd_addr_i = 1; tick("R9 addr3 write");
        check("R9 enables kept", rd_data_o, 8'h04);

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            tx_load_i     = ($urandom % 4) == 0;
            rx_push_i     = ($urandom % 4) == 0;
            rx_drained_i  = ($urandom % 4) == 0;
            err_overrun_i = ($urandom % 8) == 0;
            err_framing_i = ($urandom % 8) == 0;
            err_parity_i  = ($urandom % 8) == 0;
            wr_en_i       = ($urandom % 3) == 0;
            wr_addr_i     = 2'($urandom);
            wr_data_i     = 8'($urandom);
            rd_addr_i     = 2'($urandom);
            tick("R5 random");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule